// File: doc/BRIEF.md
# Four-Stage Pipeline Controller with Injected Filler Operations

This block is the control skeleton of an in-order pipeline with four stages: fetch, decode, execute and write-back. Instruction tokens come in through a valid/ready handshake. Each token carries a two-bit operation class, a machine-cycle count and an identifying tag. Tokens move forward one stage per clock, and the block reports the occupancy of each stage together with the instructions that retire from write-back.

Some instructions need more than one machine cycle. For these, and for every accepted interrupt, the block creates filler operations and places them directly into decode. While it does so, the token in fetch is held and input ready is low. Fillers then pass through execute and write-back like real instructions, but they never appear as retired.

The block has three side outputs:
- a redirect pulse, raised while a branch sits in decode;
- a stack-step pulse, raised while a stack operation sits in decode;
- a flag-write pulse, raised while a special-register write sits in execute.

Top module: `pipe4_ctrl`

## Requirements
- R1: A token accepted at a clock edge occupies fetch, decode, execute and write-back on the four following cycles, one stage per cycle, as long as no filler is injected. `stage_occ` bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 write-back.
- R2: A continuous stream of single-cycle tokens retires one token per cycle once the pipe is full.
- R3: `retire_valid` is high only for real tokens, never for fillers. Tokens retire in acceptance order, with `retire_tag` showing the accepted tag, and a discarded token never retires.
- R4: A real token whose cycle field N is above 1 causes N-1 fillers to enter decode on the N-1 cycles after it leaves decode. During those cycles `in_ready` is low and fetch keeps its token. A cycle field of 0 or 1 means a single-cycle token and injects nothing.
- R5: An interrupt request is taken when no multi-cycle injection is starting or pending. It injects IRQ_SLOTS fillers into decode, and in_ready is low in the cycle the request is taken. `irq_ack` is high exactly in the cycle the first interrupt filler sits in decode, and the requester drops the request in that cycle.
- R6: A real token of class 1 (branch) in decode raises `redirect` in that cycle and discards the token held in fetch. A token accepted in that same cycle is kept.
- R7: `sp_step` is high while a real token of class 2 (stack) is in decode. `flag_wr` is high while a real token of class 3 (special-register write) is in execute.
- R8: After reset every stage is empty, `retire_valid` and `irq_ack` are low and `in_ready` is high.
- R9: `stage_filler` marks, per stage and with the same bit order as `stage_occ`, that the stage holds a filler. Fetch never holds one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Token can be taken this cycle |
| in_op | input | 2 | Operation class: 0 plain, 1 branch, 2 stack, 3 special-register write |
| in_cycles | input | TOK_CYC_W | Machine cycles needed by the token |
| in_tag | input | TOK_TAG_W | Token identifier |
| irq_req | input | 1 | Interrupt request, level |
| irq_ack | output | 1 | First interrupt filler is in decode |
| stage_occ | output | 4 | Stage holds a token or filler |
| stage_filler | output | 4 | Stage holds a filler |
| redirect | output | 1 | Branch in decode, fetch discarded |
| sp_step | output | 1 | Stack operation in decode |
| flag_wr | output | 1 | Special-register write in execute |
| retire_valid | output | 1 | Real token leaves write-back |
| retire_tag | output | TOK_TAG_W | Tag of the retiring token |

## Verification
Outputs settle at different times after a stimulus:
- `in_ready` and `redirect` respond combinationally, within the same cycle.
- `irq_ack` rises one cycle after the request is taken.
- `sp_step` is due two cycles after acceptance and `flag_wr` three cycles after.
- Retirement of an undelayed token is due four cycles after acceptance, and a token behind an N-cycle token retires N cycles after it.

The bench numbers every cycle and samples all outputs in the middle of it. It records the cycle of each acceptance, retire and pulse, and compares the differences to the expected offsets. Random traffic is checked for retire order against a queue built only from the handshake and the branch-discard rule.

// File: rtl/pipe4_pkg.sv
// Shared types for the four-stage pipeline controller.
package pipe4_pkg;
    parameter int TOK_TAG_W = 8;
    parameter int TOK_CYC_W = 3;

    typedef enum logic [1:0] {
        OP_PLAIN  = 2'd0,
        OP_BRANCH = 2'd1,
        OP_STACK  = 2'd2,
        OP_SREG   = 2'd3
    } op_e;

    typedef struct packed {
        logic                 valid;
        logic                 filler;
        op_e                  op;
        logic [TOK_CYC_W-1:0] cyc;
        logic [TOK_TAG_W-1:0] tag;
    } stage_t;

    localparam stage_t STAGE_EMPTY = '0;
endpackage

// File: rtl/pipe4_stage_reg.sv
// One pipeline stage register.
// Assumes: the next-state value is fully decided by the parent; resets to empty.
module pipe4_stage_reg
    import pipe4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t d,
    output stage_t q
);
    // Load the next stage content each cycle, empty on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= STAGE_EMPTY;
        else        q <= d;
    end
endmodule

// File: rtl/pipe4_inject_ctrl.sv
// Decides when fillers enter decode, counts pending fillers, acknowledges interrupts.
// Assumes: the requester drops irq_req in the cycle irq_ack is high; IRQ_SLOTS >= 1.
module pipe4_inject_ctrl
    import pipe4_pkg::*;
#(
    parameter int IRQ_SLOTS = 2
)(
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t dec_q,
    input  logic   irq_req,
    output logic   inject,
    output logic   irq_ack
);
    localparam int IRQ_W = $clog2(IRQ_SLOTS) + 1;
    localparam int CNT_W = (TOK_CYC_W > IRQ_W) ? TOK_CYC_W : IRQ_W;

    logic [CNT_W-1:0] pend_q;
    logic             mc_start;
    logic             irq_take;
    logic             ack_q;

    // Classify this cycle: multi-cycle start, pending fillers or interrupt entry.
    always_comb begin
        mc_start = dec_q.valid && !dec_q.filler && (dec_q.cyc > TOK_CYC_W'(1));
        irq_take = irq_req && !mc_start && (pend_q == '0);
        inject   = mc_start || (pend_q != '0) || irq_take;
    end

    // Track fillers still owed and register the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            ack_q <= irq_take;
            if (mc_start)
                pend_q <= CNT_W'(dec_q.cyc) - CNT_W'(2);
            else if (pend_q != '0)
                pend_q <= pend_q - CNT_W'(1);
            else if (irq_take)
                pend_q <= CNT_W'(IRQ_SLOTS - 1);
        end
    end

    assign irq_ack = ack_q;
endmodule

// File: rtl/pipe4_ctrl.sv
// Four-stage in-order pipeline control: fetch, decode, execute, write-back.
// Fillers are injected into decode for multi-cycle tokens and interrupt entry;
// a branch in decode discards the token in fetch.
// Assumes: write-back always drains, so execute and write-back never stall.
module pipe4_ctrl
    import pipe4_pkg::*;
#(
    parameter int IRQ_SLOTS = 2
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           in_op,
    input  logic [TOK_CYC_W-1:0] in_cycles,
    input  logic [TOK_TAG_W-1:0] in_tag,
    input  logic                 irq_req,
    output logic                 irq_ack,
    output logic [3:0]           stage_occ,
    output logic [3:0]           stage_filler,
    output logic                 redirect,
    output logic                 sp_step,
    output logic                 flag_wr,
    output logic                 retire_valid,
    output logic [TOK_TAG_W-1:0] retire_tag
);
    localparam int NSTG = 4;
    localparam int ST_F = 0;
    localparam int ST_D = 1;
    localparam int ST_E = 2;
    localparam int ST_W = 3;

    stage_t stage_q [NSTG];
    stage_t stage_d [NSTG];
    stage_t in_tok;
    stage_t fill_tok;
    logic   inject;
    logic   accept;

    pipe4_inject_ctrl #(.IRQ_SLOTS(IRQ_SLOTS)) inj_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_q   (stage_q[ST_D]),
        .irq_req (irq_req),
        .inject  (inject),
        .irq_ack (irq_ack)
    );

    // Build the incoming token and the filler template.
    always_comb begin
        in_tok   = '{valid: 1'b1, filler: 1'b0, op: op_e'(in_op), cyc: in_cycles, tag: in_tag};
        fill_tok = '{valid: 1'b1, filler: 1'b1, op: OP_PLAIN, cyc: TOK_CYC_W'(1), tag: '0};
    end

    // Handshake, redirect and side pulses.
    always_comb begin
        in_ready = !inject;
        accept   = in_valid && in_ready;
        redirect = stage_q[ST_D].valid && !stage_q[ST_D].filler && (stage_q[ST_D].op == OP_BRANCH);
        sp_step  = stage_q[ST_D].valid && !stage_q[ST_D].filler && (stage_q[ST_D].op == OP_STACK);
        flag_wr  = stage_q[ST_E].valid && !stage_q[ST_E].filler && (stage_q[ST_E].op == OP_SREG);
    end

    // Next content of every stage: injection holds fetch, redirect discards it.
    always_comb begin
        stage_d[ST_W] = stage_q[ST_E];
        stage_d[ST_E] = stage_q[ST_D];
        if (inject) begin
            stage_d[ST_D] = fill_tok;
            stage_d[ST_F] = redirect ? STAGE_EMPTY : stage_q[ST_F];
        end else begin
            stage_d[ST_D] = redirect ? STAGE_EMPTY : stage_q[ST_F];
            stage_d[ST_F] = accept ? in_tok : STAGE_EMPTY;
        end
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        pipe4_stage_reg stg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (stage_d[g]),
            .q     (stage_q[g])
        );
        assign stage_occ[g]    = stage_q[g].valid;
        assign stage_filler[g] = stage_q[g].valid && stage_q[g].filler;
    end

    // Retire port: only real tokens leaving write-back.
    always_comb begin
        retire_valid = stage_q[ST_W].valid && !stage_q[ST_W].filler;
        retire_tag   = stage_q[ST_W].tag;
    end
endmodule

// File: rtl/pipe4_ctrl_chk.sv
// Temporal checks on the pipeline controller ports, bound to every instance.
module pipe4_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       irq_ack,
    input logic [3:0] stage_occ,
    input logic [3:0] stage_filler,
    input logic       redirect,
    input logic       retire_valid
);
    // R1: execute and write-back take what the previous stage held.
    a_r1_stage_flow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage_occ[2] == $past(stage_occ[1])) && (stage_occ[3] == $past(stage_occ[2])));

    // R3: a filler in execute never shows up as a retire.
    a_r3_filler_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
        stage_filler[2] |=> !retire_valid);

    // R4: a cycle with ready low puts a filler into decode.
    a_r4_hold_means_filler: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (stage_occ[1] && stage_filler[1]));

    // R5: acknowledge coincides with a filler in decode.
    a_r5_ack_with_filler: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (stage_occ[1] && stage_filler[1]));

    // R6: after a redirect decode holds a bubble or a filler, never the discarded token.
    a_r6_redirect_discard: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!stage_occ[1] || stage_filler[1]));
endmodule

bind pipe4_ctrl pipe4_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .irq_ack      (irq_ack),
    .stage_occ    (stage_occ),
    .stage_filler (stage_filler),
    .redirect     (redirect),
    .retire_valid (retire_valid)
);

// File: tb/pipe4_ctrl_tb_top.sv
module pipe4_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 100000;
    localparam int IRQ_SLOTS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_op = 2'd0;
    logic [2:0] in_cycles = 3'd1;
    logic [7:0] in_tag = 8'd0;
    logic       irq_req = 1'b0;
    logic       irq_ack;
    logic [3:0] stage_occ;
    logic [3:0] stage_filler;
    logic       redirect;
    logic       sp_step;
    logic       flag_wr;
    logic       retire_valid;
    logic [7:0] retire_tag;

    int checks = 0;
    int failures = 0;
    int tick_no = 0;
    bit done = 0;
    bit last_acc = 0;
    int last_acc_tick = 0;
    int ready_low = 0;
    int redir_tick = -1;
    int sp_tick = -1;
    int fw_tick = -1;
    bit br_pend = 0;
    int ret_tick [256];
    logic [7:0] exp_q [$];

    pipe4_ctrl #(.IRQ_SLOTS(IRQ_SLOTS)) dut_i (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: observe mid-cycle after inputs settle, then move to next negedge.
    task automatic tick();
        bit dropped;
        #1;
        dropped  = 0;
        last_acc = in_valid && in_ready;
        if (last_acc) last_acc_tick = tick_no;
        if (!in_ready) ready_low++;
        if (redirect) redir_tick = tick_no;
        if (sp_step) sp_tick = tick_no;
        if (flag_wr) fw_tick = tick_no;
        if (in_ready && br_pend) begin
            if (last_acc) dropped = 1;
            br_pend = 0;
        end
        if (last_acc && !dropped) begin
            exp_q.push_back(in_tag);
            if (in_op == 2'd1) br_pend = 1;
        end
        if (retire_valid) begin
            ret_tick[retire_tag] = tick_no;
            if (exp_q.size() == 0) chk(0, "R3 unexpected retire", retire_tag, -1);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(retire_tag == e, "R3 retire order", retire_tag, e);
            end
        end
        if (irq_ack) chk(stage_filler[1] && stage_occ[1], "R5 ack with filler", stage_filler, 2);
        chk(!stage_filler[0], "R9 no filler in fetch", stage_filler[0], 0);
        tick_no++;
        @(negedge clk);
    endtask

    task automatic send(input logic [1:0] op, input logic [2:0] cyc, input logic [7:0] tag);
        in_valid = 1; in_op = op; in_cycles = cyc; in_tag = tag;
        for (int g = 0; g < 50; g++) begin
            tick();
            if (last_acc) break;
        end
        in_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", tick_no, 0);
            finish_run();
        end
    end

    initial begin
        int a, s, rl;
        for (int i = 0; i < 256; i++) ret_tick[i] = -1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R8 reset state
        chk(stage_occ == 4'b0, "R8 empty", stage_occ, 0);
        chk(in_ready == 1'b1, "R8 ready", in_ready, 1);
        chk(!irq_ack && !retire_valid, "R8 ack/retire low", {irq_ack, retire_valid}, 0);
        @(negedge clk);

        // R1 / R9 single token walks through stages
        send(2'd0, 3'd1, 8'h11);
        a = last_acc_tick;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk(stage_occ == 4'(1 << k), "R1 R9 occupancy", stage_occ, 1 << k);
            tick();
        end
        chk(ret_tick[8'h11] == a + 4, "R1 latency", ret_tick[8'h11] - a, 4);

        // R2 back-to-back stream
        idle(4);
        send(2'd0, 3'd1, 8'h20);
        s = last_acc_tick;
        for (int i = 1; i < 6; i++) send(2'd0, 3'd1, 8'(8'h20 + i));
        idle(8);
        chk(ret_tick[8'h20] == s + 4, "R2 first retire", ret_tick[8'h20] - s, 4);
        for (int i = 1; i < 6; i++)
            chk(ret_tick[8'h20 + i] == ret_tick[8'h20] + i, "R2 one per cycle",
                ret_tick[8'h20 + i] - ret_tick[8'h20], i);

        // R4 multi-cycle token stalls fetch for N-1 cycles
        rl = ready_low;
        send(2'd0, 3'd3, 8'h60);
        send(2'd0, 3'd1, 8'h61);
        send(2'd0, 3'd1, 8'h62);
        idle(8);
        chk(ready_low - rl == 2, "R4 ready low cycles", ready_low - rl, 2);
        chk(ret_tick[8'h61] - ret_tick[8'h60] == 3, "R4 retire gap", ret_tick[8'h61] - ret_tick[8'h60], 3);

        // R4 cycle field 0 and 1 inject nothing
        rl = ready_low;
        send(2'd0, 3'd0, 8'h30);
        send(2'd0, 3'd0, 8'h31);
        send(2'd0, 3'd1, 8'h32);
        idle(8);
        chk(ready_low == rl, "R4 zero-cycle no stall", ready_low - rl, 0);
        chk(ret_tick[8'h32] - ret_tick[8'h30] == 2, "R4 zero-cycle flow", ret_tick[8'h32] - ret_tick[8'h30], 2);

        // R5 interrupt on idle pipe
        irq_req = 1;
        #1;
        chk(!in_ready, "R5 ready low on take", in_ready, 0);
        tick();
        #1;
        chk(irq_ack && stage_filler[1], "R5 ack cycle", {irq_ack, stage_filler[1]}, 3);
        irq_req = 0;
        tick();
        #1;
        chk(!irq_ack && stage_filler[1], "R5 second filler", {irq_ack, stage_filler[1]}, 1);
        tick();
        #1;
        chk(!stage_filler[1] && !in_ready == 0, "R5 fillers done", stage_filler[1], 0);
        idle(6);

        // R6 branch discards token in fetch
        send(2'd1, 3'd1, 8'h40);
        send(2'd0, 3'd1, 8'h41);
        send(2'd0, 3'd1, 8'h42);
        a = last_acc_tick;
        idle(8);
        chk(redir_tick == a, "R6 redirect cycle", redir_tick - a, 0);
        chk(ret_tick[8'h41] == -1, "R6 discarded", ret_tick[8'h41], -1);
        chk(ret_tick[8'h42] - ret_tick[8'h40] == 2, "R6 kept token", ret_tick[8'h42] - ret_tick[8'h40], 2);

        // R7 stack and special-register pulses
        send(2'd2, 3'd1, 8'h50);
        a = last_acc_tick;
        idle(6);
        chk(sp_tick == a + 2, "R7 sp_step timing", sp_tick - a, 2);
        send(2'd3, 3'd1, 8'h51);
        a = last_acc_tick;
        idle(6);
        chk(fw_tick == a + 3, "R7 flag_wr timing", fw_tick - a, 3);

        // Random traffic with interrupts, R3 order via the expectation queue
        void'($urandom(32'd4242));
        for (int c = 0; c < 3000; c++) begin
            if (irq_ack) irq_req = 0;
            else if (!irq_req && ($urandom % 40) == 0) irq_req = 1;
            if (!(in_valid && !last_acc)) begin
                in_valid  = ($urandom % 10) < 7;
                in_op     = 2'($urandom);
                in_cycles = 3'($urandom % 4);
                in_tag    = 8'($urandom);
            end
            tick();
        end
        in_valid = 0;
        irq_req = 0;
        idle(20);
        chk(exp_q.size() == 0, "R3 all retired", exp_q.size(), 0);

        done = 1;
        finish_run();
    end
endmodule